// File: doc/BRIEF.md
# Two-Wire Serial Clock Divider

This block derives the serial clock for a two-wire bus master from a much faster system clock. The clock passes through a chain of dividers. A high-period counter wraps every THP+1 system cycles. A power-of-two stage then divides by 2^N, and an M+1 stage divides by M+1. The result is one tick per (THP+1)·2^N·(M+1) system cycles. Each phase of the serial clock lasts ten such ticks, so a full period is 20·(THP+1)·2^N·(M+1) cycles. This equals the rate f_sys / (2·(THP+1)) / 2^N / (M+1) / 10.

Software writes the divisors through two write strobes. One loads the 8-bit high-period count. The other loads a 7-bit clock-control word. Both writes land in staging registers. The divider copies them into its working set only when a low phase ends, so a period never changes while it is in progress. The tick output goes to the byte engine, which uses it to place data and sample points. Bus stretching by a slave is supported: while the block releases SCL high but the sampled line is still low, the divider stops counting.

Top module: `twsi_scl_divider`

## Requirements
- R1: After reset, scl_out is 1 and scl_tick is 0. The working divisors are THP=24, M=2, N=0, so the first full period lasts 1500 system cycles.
- R2: Without stretching, the SCL period is 20·(THP+1)·2^N·(M+1) system cycles. The high phase and the low phase each last half of that. Each period starts with its high phase.
- R3: The clock-control write data carries M in bits 6:3 and N in bits 2:0.
- R4: A high-period write with a value below 5 is ignored, and the previous staged value stays.
- R5: A clock-control write whose M field is below 2 is ignored as a whole, including its N field.
- R6: Staged values become active only at the rising SCL edge that ends a low phase. A phase already in progress keeps its length.
- R7: scl_tick pulses for one cycle every (THP+1)·2^N·(M+1) counted cycles, which gives 20 pulses per period. Every SCL transition occurs in a cycle where scl_tick is high.
- R8: While scl_out is 1 and scl_in is 0, all divider counting is frozen, so the high phase grows by exactly the held cycles. A low scl_in during the low phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thp_we | input | 1 | Write strobe for the high-period count |
| thp_wdata | input | 8 | High-period count value |
| clkctl_we | input | 1 | Write strobe for the clock-control word |
| clkctl_wdata | input | 7 | M in bits 6:3, N in bits 2:0 |
| scl_in | input | 1 | Sampled SCL line level, already synchronous to clk |
| scl_out | output | 1 | SCL level the block drives (0 means pull low) |
| scl_tick | output | 1 | Single-cycle tick, 20 per SCL period |

## Verification
All outputs are registered. An SCL edge and its tick therefore appear in the same cycle: the cycle after the system edge on which the last counter stage wraps. A write strobe reaches the outputs no earlier than the next low-to-high boundary. The bench drives inputs and samples outputs on the falling clock edge. It updates a behavioural model of cycle position on each rising edge and compares scl_out and scl_tick on every cycle. Phase and period lengths are measured from the time stamps of SCL edges and compared with the formula, including runs with a mid-phase write and with a held line.

// File: rtl/twsi_scl_divider.sv
module twsi_scl_divider #(
  parameter int THP_W           = 8,
  parameter int M_W             = 4,
  parameter int N_W             = 3,
  parameter int TICKS_PER_PHASE = 10,
  parameter int THP_RST         = 24,
  parameter int M_RST           = 2,
  parameter int N_RST           = 0,
  parameter int THP_MIN         = 5,
  parameter int M_MIN           = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               thp_we,
  input  logic [THP_W-1:0]   thp_wdata,
  input  logic               clkctl_we,
  input  logic [M_W+N_W-1:0] clkctl_wdata,
  input  logic               scl_in,
  output logic               scl_out,
  output logic               scl_tick
);
  localparam int P2_W = (1 << N_W) - 1;
  localparam int PH_W = $clog2(TICKS_PER_PHASE);

  logic [THP_W-1:0] thp_stg, thp_act;
  logic [M_W-1:0]   m_stg, m_act;
  logic [N_W-1:0]   n_stg, n_act;

  logic [THP_W-1:0] c_hp;
  logic [P2_W-1:0]  c_p2;
  logic [M_W-1:0]   c_m;
  logic [PH_W-1:0]  c_ph;

  logic [P2_W-1:0] p2_lim;
  logic adv, w_hp, w_p2, w_m, w_ph, boundary;
  logic [M_W-1:0] wr_m;

  assign wr_m     = clkctl_wdata[M_W+N_W-1:N_W];
  assign p2_lim   = P2_W'((1 << n_act) - 1);
  assign adv      = !(scl_out && !scl_in);
  assign w_hp     = adv && (c_hp == thp_act);
  assign w_p2     = w_hp && (c_p2 == p2_lim);
  assign w_m      = w_p2 && (c_m == m_act);
  assign w_ph     = w_m && (c_ph == PH_W'(TICKS_PER_PHASE - 1));
  assign boundary = w_ph && !scl_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thp_stg <= THP_W'(THP_RST);
      m_stg   <= M_W'(M_RST);
      n_stg   <= N_W'(N_RST);
    end else begin
      if (thp_we && thp_wdata >= THP_W'(THP_MIN)) thp_stg <= thp_wdata;
      if (clkctl_we && wr_m >= M_W'(M_MIN)) begin
        m_stg <= wr_m;
        n_stg <= clkctl_wdata[N_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thp_act <= THP_W'(THP_RST);
      m_act   <= M_W'(M_RST);
      n_act   <= N_W'(N_RST);
    end else if (boundary) begin
      thp_act <= thp_stg;
      m_act   <= m_stg;
      n_act   <= n_stg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_hp     <= '0;
      c_p2     <= '0;
      c_m      <= '0;
      c_ph     <= '0;
      scl_out  <= 1'b1;
      scl_tick <= 1'b0;
    end else begin
      scl_tick <= w_m;
      if (adv)  c_hp <= w_hp ? '0 : c_hp + 1'b1;
      if (w_hp) c_p2 <= w_p2 ? '0 : c_p2 + 1'b1;
      if (w_p2) c_m  <= w_m  ? '0 : c_m  + 1'b1;
      if (w_m)  c_ph <= w_ph ? '0 : c_ph + 1'b1;
      if (w_ph) scl_out <= !scl_out;
    end
  end

  assert_thp_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    thp_stg >= THP_W'(THP_MIN));

  assert_m_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_stg >= M_W'(M_MIN));

  assert_load_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(thp_act) |-> $rose(scl_out));

  assert_edge_has_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_out != $past(scl_out)) |-> scl_tick);

  assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_tick |=> !scl_tick);

  assert_stretch_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_out && !scl_in) |=> ($stable(c_hp) && $stable(scl_out) && !scl_tick));
endmodule

// File: tb/tb_twsi_scl_divider.sv
module tb_twsi_scl_divider;
  logic clk = 0, rst_n = 0;
  logic thp_we = 0, clkctl_we = 0, hold = 0;
  logic [7:0] thp_wdata = 0;
  logic [6:0] clkctl_wdata = 0;
  logic scl_in, scl_out, scl_tick;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign scl_in = scl_out & ~hold;

  twsi_scl_divider dut (.clk, .rst_n, .thp_we, .thp_wdata, .clkctl_we,
                        .clkctl_wdata, .scl_in, .scl_out, .scl_tick);

  int pos, t_cyc, s_thp, s_m, s_n, a_thp, a_m, a_n;
  bit e_scl, e_tick;
  always @(posedge clk) begin
    if (!rst_n) begin
      pos = 0; e_scl = 1; e_tick = 0;
      a_thp = 24; a_m = 2; a_n = 0; s_thp = 24; s_m = 2; s_n = 0;
    end else begin
      t_cyc = (a_thp + 1) * (1 << a_n) * (a_m + 1);
      e_tick = 0;
      if (!(e_scl && hold)) begin
        pos++;
        if (pos % t_cyc == 0) e_tick = 1;
      end
      if (pos == 10 * t_cyc) begin
        pos = 0;
        if (e_scl) e_scl = 0;
        else begin e_scl = 1; a_thp = s_thp; a_m = s_m; a_n = s_n; end
      end
      if (thp_we && thp_wdata >= 5) s_thp = thp_wdata;
      if (clkctl_we && clkctl_wdata[6:3] >= 2) begin
        s_m = clkctl_wdata[6:3]; s_n = clkctl_wdata[2:0];
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (scl_out !== e_scl) begin fails++;
      $display("FAIL R2 cycle model scl_out: actual %0b expected %0b", scl_out, e_scl); end
    checks++;
    if (scl_tick !== e_tick) begin fails++;
      $display("FAIL R7 cycle model scl_tick: actual %0b expected %0b", scl_tick, e_tick); end
  end

  int tick_cnt = 0;
  always @(negedge clk) if (scl_tick === 1'b1) tick_cnt++;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp); end
  endtask

  task automatic wr_thp(input logic [7:0] v);
    @(negedge clk); thp_we = 1; thp_wdata = v; @(negedge clk); thp_we = 0;
  endtask
  task automatic wr_cc(input logic [3:0] m, input logic [2:0] n);
    @(negedge clk); clkctl_we = 1; clkctl_wdata = {m, n}; @(negedge clk); clkctl_we = 0;
  endtask

  task automatic measure(input string tag, input longint exp);
    longint t0, t1, t2; int k0;
    @(posedge scl_out); t0 = $time; k0 = tick_cnt;
    @(negedge scl_out); t1 = $time;
    @(posedge scl_out); t2 = $time;
    check({tag, " high phase"}, (t1 - t0) / 4, exp / 2);
    check({tag, " period"}, (t2 - t0) / 4, exp);
    #1; check("R7 ticks per period", tick_cnt - k0, 20);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    longint t0, t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset scl_out", scl_out, 1);
    check("R1 reset scl_tick", scl_tick, 0);
    @(negedge scl_out); t1 = $time;
    @(posedge scl_out); t2 = $time;
    check("R1 default low phase", (t2 - t1) / 4, 750);
    measure("R1 default", 1500);

    wr_thp(8'd5); wr_cc(4'd2, 3'd0);
    measure("R2 THP5 M2 N0", 360);

    wr_thp(8'd7); wr_cc(4'd3, 3'd1);
    measure("R3 THP7 M3 N1", 1280);

    wr_thp(8'd3);
    measure("R4 THP below floor ignored", 1280);
    wr_cc(4'd1, 3'd2);
    measure("R5 M below floor ignored", 1280);

    @(posedge scl_out); t0 = $time;
    repeat (100) @(negedge clk);
    wr_thp(8'd5); wr_cc(4'd2, 3'd2);
    @(negedge scl_out); t1 = $time;
    check("R6 phase in progress unchanged", (t1 - t0) / 4, 640);
    measure("R6 new values after boundary", 1440);

    @(posedge scl_out); t0 = $time;
    repeat (10) @(negedge clk);
    hold = 1; repeat (50) @(negedge clk); hold = 0;
    @(negedge scl_out); t1 = $time;
    check("R8 stretched high phase", (t1 - t0) / 4, 720 + 50);
    repeat (10) @(negedge clk);
    hold = 1; repeat (30) @(negedge clk); hold = 0;
    @(posedge scl_out); t2 = $time;
    check("R8 low phase not stretched", (t2 - t1) / 4, 720);
    measure("R2 after stretch", 1440);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule